// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits between a host bus and the embedded program and erase engines of a flash array. It watches write cycles, each made of an address, a data word and the three active-low bus strobes. It accepts an operation only after a two-write unlock key has been written. A command write follows the key. For erase, a second key and a confirm write also follow. An accepted operation is announced by a one-cycle start pulse, and the pulse carries the captured address and data.

The location of the key depends on a mode input. In word addressing the key goes to 555h and then 2AAh. In byte addressing the address carries one more low bit, so the key goes to AAAh and then 555h. A write that breaks the expected pattern discards any partial sequence, and so does an F0h reset write. The decoder then waits for a new key. While the busy input is high every bus write is ignored and the partial sequence is kept.

Each clock in which the write qualifier is true counts as exactly one bus write.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: While `rst` is high, the decoder goes to the read-array state within one clock. All start pulses are low and `autosel_mode` is low on the clock after `rst` is seen, and any partial sequence is lost.
- R2: A clock counts as a write only when `ce_n`=0, `we_n`=0 and `oe_n`=1. Any other strobe combination has no effect on state or outputs.
- R3: The unlock key is data AAh then 55h. In word mode (`byte_mode`=0) the addresses are 555h then 2AAh, compared on address bits 10..0. In byte mode (`byte_mode`=1) the addresses are AAAh then 555h, compared on bits 11..0.
- R4: Key, then A0h at the first key address, then any fourth write. The clock after the fourth write has `pgm_start`=1 for one cycle, with `op_addr` and `op_data` equal to that write's full address and 16-bit data. The fourth write is always taken as program data, even when its value is F0h.
- R5: Key, then 90h at the first key address. `autosel_mode` is 1 from the next clock. The next accepted write of any kind clears it.
- R6: Key, then 80h at the first key address, key again, then 10h at the first key address. This produces a one-cycle `chip_erase_start`.
- R7: Key, then 80h, then key, then 30h at any address. This produces a one-cycle `sector_erase_start` with `op_addr` equal to that address.
- R8: A write with data bits 7..0 equal to F0h, in any state other than the program-data state, returns the decoder to read-array with no start pulse.
- R9: A write with a wrong address or wrong data at any step returns the decoder to read-array. A following command write then does nothing.
- R10: While `busy`=1 a write is ignored and the partial sequence is kept. No start pulse follows a busy clock.
- R11: Data bits 15..8 are ignored in key and command cycles. Address bits above the key window are also ignored there.
- R12: No more than one start pulse is high in any clock, and none lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to read-array |
| byte_mode | input | 1 | 1 selects byte addressing of the key |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | An embedded algorithm is running; writes are ignored |
| addr | input | ADDR_W (20) | Write address |
| wdata | input | DATA_W (16) | Write data |
| pgm_start | output | 1 | One-cycle program start |
| chip_erase_start | output | 1 | One-cycle chip erase start |
| sector_erase_start | output | 1 | One-cycle sector erase start |
| autosel_mode | output | 1 | Identification read mode is active |
| op_addr | output | ADDR_W (20) | Address captured with the last start |
| op_data | output | DATA_W (16) | Data captured with the last start |

## Verification
The bench builds the block with ADDR_W=20, DATA_W=16 and KEY_BITS=11. This leaves eight address bits above the key window, so the bench can drive set upper bits and non-zero high data bytes during key cycles. Those upper bits must be ignored there, yet must appear in the captured program and sector addresses. With these parameter values the byte-mode key uses address bit 11. This means a word-mode key written while byte mode is selected must fail, and the bench checks that it does.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PGM, ST_ERS0, ST_ERS1, ST_ERS2, ST_ASEL
  } ucd_state_e;

  localparam logic [7:0] CODE_KEY1   = 8'hAA;
  localparam logic [7:0] CODE_KEY2   = 8'h55;
  localparam logic [7:0] CODE_PGM    = 8'hA0;
  localparam logic [7:0] CODE_ASEL   = 8'h90;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
endpackage

// File: rtl/ucd_key_match.sv
module ucd_key_match #(
  parameter int KEY_BITS = 11,
  parameter logic [KEY_BITS-1:0] KEY1 = 'h555,
  parameter logic [KEY_BITS-1:0] KEY2 = 'h2AA
) (
  input  logic [KEY_BITS:0] addr_lo,
  input  logic              byte_mode,
  output logic              at_k1,
  output logic              at_k2
);
  // byte addressing appends the half-word select bit below the word key
  localparam logic [KEY_BITS:0] BKEY1 = {KEY1, 1'b0};
  localparam logic [KEY_BITS:0] BKEY2 = {KEY2, 1'b1};

  always_comb begin
    if (byte_mode) begin
      at_k1 = (addr_lo == BKEY1);
      at_k2 = (addr_lo == BKEY2);
    end else begin
      at_k1 = (addr_lo[KEY_BITS-1:0] == KEY1);
      at_k2 = (addr_lo[KEY_BITS-1:0] == KEY2);
    end
  end
endmodule

// File: rtl/ucd_cmd_fsm.sv
module ucd_cmd_fsm
  import ucd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic              at_k1,
  input  logic              at_k2,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              pgm_start,
  output logic              chip_erase_start,
  output logic              sector_erase_start,
  output logic              autosel_mode,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  ucd_state_e st_q, st_d;
  logic [7:0] lo;
  logic fire_pgm, fire_chip, fire_sec;

  assign lo = wdata[7:0];

  always_comb begin
    st_d      = st_q;
    fire_pgm  = 1'b0;
    fire_chip = 1'b0;
    fire_sec  = 1'b0;
    if (wr_ok) begin
      unique case (st_q)
        ST_PGM: begin
          fire_pgm = 1'b1;
          st_d     = ST_READ;
        end
        ST_ASEL: st_d = ST_READ;
        default: begin
          // anything unmatched, including F0h, lands in read-array
          st_d = ST_READ;
          case (st_q)
            ST_READ: if (at_k1 && lo == CODE_KEY1) st_d = ST_UNL1;
            ST_UNL1: if (at_k2 && lo == CODE_KEY2) st_d = ST_UNL2;
            ST_UNL2: if (at_k1) begin
              if (lo == CODE_PGM)        st_d = ST_PGM;
              else if (lo == CODE_ASEL)  st_d = ST_ASEL;
              else if (lo == CODE_ERASE) st_d = ST_ERS0;
            end
            ST_ERS0: if (at_k1 && lo == CODE_KEY1) st_d = ST_ERS1;
            ST_ERS1: if (at_k2 && lo == CODE_KEY2) st_d = ST_ERS2;
            ST_ERS2: begin
              if (at_k1 && lo == CODE_CHIP) fire_chip = 1'b1;
              else if (lo == CODE_SECTOR)   fire_sec  = 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q               <= ST_READ;
      pgm_start          <= 1'b0;
      chip_erase_start   <= 1'b0;
      sector_erase_start <= 1'b0;
      autosel_mode       <= 1'b0;
      op_addr            <= '0;
      op_data            <= '0;
    end else begin
      st_q               <= st_d;
      pgm_start          <= fire_pgm;
      chip_erase_start   <= fire_chip;
      sector_erase_start <= fire_sec;
      autosel_mode       <= (st_d == ST_ASEL);
      if (fire_pgm || fire_chip || fire_sec) begin
        op_addr <= addr;
        op_data <= wdata;
      end
    end
  end

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pgm_start, chip_erase_start, sector_erase_start})); // R12
  AST_PGM_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pgm_start |=> !pgm_start); // R12
  AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (chip_erase_start || sector_erase_start) |=> !(chip_erase_start || sector_erase_start)); // R12
  AST_ASEL_EXIT: assert property (@(posedge clk) disable iff (rst)
    (autosel_mode && wr_ok) |=> !autosel_mode); // R5
endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int KEY_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_mode,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              pgm_start,
  output logic              chip_erase_start,
  output logic              sector_erase_start,
  output logic              autosel_mode,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  localparam int WIN_W = KEY_BITS + 1;

  logic bus_wr, wr_ok, at_k1, at_k2;

  assign bus_wr = !ce_n && !we_n && oe_n;
  assign wr_ok  = bus_wr && !busy;

  ucd_key_match #(.KEY_BITS(KEY_BITS)) u_match (
    .addr_lo   (addr[WIN_W-1:0]),
    .byte_mode (byte_mode),
    .at_k1     (at_k1),
    .at_k2     (at_k2)
  );

  ucd_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk                (clk),
    .rst                (rst),
    .wr_ok              (wr_ok),
    .at_k1              (at_k1),
    .at_k2              (at_k2),
    .addr               (addr),
    .wdata              (wdata),
    .pgm_start          (pgm_start),
    .chip_erase_start   (chip_erase_start),
    .sector_erase_start (sector_erase_start),
    .autosel_mode       (autosel_mode),
    .op_addr            (op_addr),
    .op_data            (op_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !(pgm_start || chip_erase_start || sector_erase_start || autosel_mode)); // R1
  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (pgm_start || chip_erase_start || sector_erase_start) |-> $past(!ce_n && !we_n && oe_n)); // R2
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(pgm_start || chip_erase_start || sector_erase_start)); // R10
  AST_BUSY_HOLDS_ASEL: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(autosel_mode)); // R10
endmodule

// File: tb/cmd_unlock_decoder_test.sv
module cmd_unlock_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_mode = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic pgm_start, chip_erase_start, sector_erase_start, autosel_mode;
  logic [19:0] op_addr;
  logic [15:0] op_data;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cmd_unlock_decoder uut (
    .clk(clk), .rst(rst), .byte_mode(byte_mode), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .busy(busy), .addr(addr), .wdata(wdata),
    .pgm_start(pgm_start), .chip_erase_start(chip_erase_start),
    .sector_erase_start(sector_erase_start), .autosel_mode(autosel_mode),
    .op_addr(op_addr), .op_data(op_data)
  );

  // behavioural reference: history of accepted writes since last idle
  typedef struct { logic [19:0] a; logic [15:0] d; } ent_t;
  ent_t hist[$];
  logic e_pgm = 0, e_chip = 0, e_sec = 0, e_as = 0;
  logic [19:0] e_addr = '0;
  logic [15:0] e_data = '0;

  function automatic bit hit(logic [19:0] a, logic [15:0] d, int k, logic [7:0] c, int m);
    return ((int'(a) & m) == k) && (d[7:0] == c);
  endfunction

  task automatic model_write(logic [19:0] a, logic [15:0] d, logic bm);
    int k1 = bm ? 'hAAA : 'h555;
    int k2 = bm ? 'h555 : 'h2AA;
    int m  = bm ? 'hFFF : 'h7FF;
    int n;
    bit good;
    ent_t e;
    if (e_as) begin e_as = 0; hist.delete(); return; end
    e.a = a; e.d = d;
    hist.push_back(e);
    n = hist.size();
    if (n == 4 && hist[2].d[7:0] == 8'hA0) begin
      e_pgm = 1; e_addr = a; e_data = d; hist.delete(); return;
    end
    good = 0;
    case (n)
      1: good = hit(a, d, k1, 8'hAA, m);
      2: good = hit(a, d, k2, 8'h55, m);
      3: good = hit(a, d, k1, 8'hA0, m) || hit(a, d, k1, 8'h80, m);
      4: good = hit(a, d, k1, 8'hAA, m);
      5: good = hit(a, d, k2, 8'h55, m);
      default: begin
        if (hit(a, d, k1, 8'h10, m)) begin e_chip = 1; e_addr = a; e_data = d; end
        else if (d[7:0] == 8'h30) begin e_sec = 1; e_addr = a; e_data = d; end
      end
    endcase
    if (n == 3 && hit(a, d, k1, 8'h90, m)) e_as = 1;
    if (!good) hist.delete();
  endtask

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      e_pgm = 0; e_chip = 0; e_sec = 0; e_as = 0; e_addr = '0; e_data = '0;
    end else begin
      e_pgm = 0; e_chip = 0; e_sec = 0;
      if (!ce_n && !we_n && oe_n && !busy) model_write(addr, wdata, byte_mode);
    end
  end

  task automatic check(string req, string what, logic [35:0] act, logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, "starts/autosel",
            {32'd0, pgm_start, chip_erase_start, sector_erase_start, autosel_mode},
            {32'd0, e_pgm, e_chip, e_sec, e_as});
      check(cur_req, "op addr/data", {op_addr, op_data}, {e_addr, e_data});
    end
  end

  task automatic drv(logic [19:0] a, logic [15:0] d, logic c, logic w, logic o, logic b);
    @(negedge clk);
    addr = a; wdata = d; ce_n = c; we_n = w; oe_n = o; busy = b;
  endtask
  task automatic wr(logic [19:0] a, logic [15:0] d);
    drv(a, d, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drv(20'h0, 16'h0, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask
  task automatic key(bit bm);
    wr(bm ? 20'hAAA : 20'h555, 16'h00AA);
    wr(bm ? 20'h555 : 20'h2AA, 16'h0055);
  endtask
  task automatic cmd(bit bm, logic [7:0] c);
    key(bm);
    wr(bm ? 20'hAAA : 20'h555, {8'h00, c});
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    check("R1", "reset outputs", {16'd0, pgm_start, chip_erase_start, sector_erase_start, autosel_mode, op_addr[15:0]}, 36'd0);

    cur_req = "R4"; // word-mode program
    cmd(0, 8'hA0); wr(20'hABCDE, 16'h1234); idle(1);
    check("R4", "pgm pulse", {35'd0, pgm_start}, 36'd1);
    check("R4", "pgm addr", {16'd0, op_addr}, {16'd0, 20'hABCDE});
    idle(2);
    check("R12", "pgm pulse width", {35'd0, pgm_start}, 36'd0);

    cur_req = "R3"; // byte-mode program; word key under byte mode must fail
    byte_mode = 1;
    cmd(1, 8'hA0); wr(20'h00042, 16'hBEEF); idle(2);
    cmd(0, 8'hA0); wr(20'h00077, 16'h7777); idle(2);
    byte_mode = 0;
    cmd(1, 8'hA0); wr(20'h00088, 16'h8888); idle(2);

    cur_req = "R5";
    cmd(0, 8'h90); idle(1);
    check("R5", "autosel on", {35'd0, autosel_mode}, 36'd1);
    idle(2);
    wr(20'h00001, 16'h0000); idle(1);
    check("R5", "autosel off", {35'd0, autosel_mode}, 36'd0);
    idle(1);

    cur_req = "R6";
    cmd(0, 8'h80); cmd(0, 8'h10); idle(2);
    byte_mode = 1; cmd(1, 8'h80); cmd(1, 8'h10); idle(2); byte_mode = 0;

    cur_req = "R7";
    cmd(0, 8'h80); key(0); wr(20'hF0000, 16'h0030); idle(1);
    check("R7", "sector pulse", {35'd0, sector_erase_start}, 36'd1);
    idle(2);

    cur_req = "R8";
    key(0); wr(20'h12345, 16'h00F0); wr(20'h555, 16'h00A0); wr(20'h00100, 16'h4444); idle(2);
    cmd(0, 8'h80); wr(20'h00000, 16'h00F0); key(0); wr(20'h555, 16'h0010); idle(2);
    cmd(0, 8'hA0); wr(20'h00200, 16'h00F0); idle(2); // F0 taken as program data (R4)

    cur_req = "R9";
    wr(20'h555, 16'h00AA); wr(20'h2AA, 16'h0056); wr(20'h555, 16'h00A0); wr(20'h00300, 16'h1111); idle(2);
    wr(20'h554, 16'h00AA); wr(20'h2AA, 16'h0055); wr(20'h555, 16'h0080); idle(2);
    cmd(0, 8'h80); key(0); wr(20'h556, 16'h0010); idle(2);
    cmd(0, 8'h42); wr(20'h00400, 16'h2222); idle(2);

    cur_req = "R10";
    wr(20'h555, 16'h00AA);
    drv(20'h999, 16'h0012, 1'b0, 1'b0, 1'b1, 1'b1);
    wr(20'h2AA, 16'h0055); wr(20'h555, 16'h00A0);
    drv(20'h00500, 16'h5555, 1'b0, 1'b0, 1'b1, 1'b1); idle(2);
    wr(20'h00600, 16'h6666); idle(2);
    cmd(0, 8'h90); drv(20'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1); idle(1);
    check("R10", "autosel kept while busy", {35'd0, autosel_mode}, 36'd1);
    wr(20'h0, 16'h00F0); idle(2);

    cur_req = "R11";
    wr(20'hFF555, 16'hFFAA); wr(20'h3A2AA, 16'h8055); wr(20'hC0555, 16'h77A0);
    wr(20'hFEDCB, 16'hCAFE); idle(2);
    cmd(0, 8'h80); wr(20'hF0555, 16'hAAAA); wr(20'h0F2AA, 16'h5555); wr(20'h88555, 16'hEE10); idle(2);

    cur_req = "R2";
    drv(20'h555, 16'h00AA, 1'b1, 1'b0, 1'b1, 1'b0);
    drv(20'h555, 16'h00AA, 1'b0, 1'b0, 1'b0, 1'b0);
    drv(20'h555, 16'h00AA, 1'b0, 1'b1, 1'b1, 1'b0);
    wr(20'h2AA, 16'h0055); wr(20'h555, 16'h00A0); wr(20'h00700, 16'h7070); idle(2);
    key(0); idle(2); wr(20'h555, 16'h00A0); wr(20'h00710, 16'h7171); idle(2);

    cur_req = "R1"; // reset mid-sequence
    cmd(0, 8'hA0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wr(20'h00800, 16'h8080); idle(2);
    check("R1", "no pgm after reset", {35'd0, pgm_start}, 36'd0);
    cmd(0, 8'h90);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", "autosel cleared", {35'd0, autosel_mode}, 36'd0);
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule